// File: doc/BRIEF.md
# Message-Signalled Interrupt Generator

This unit sits beside a peripheral and turns the peripheral's event pulses into ordinary bus writes. The peripheral does not drive an interrupt level line. The unit acts as a pipelined Wishbone master and sends one write per event. Software programs two things through a small Wishbone slave port: the destination address and the data word that each write carries. The interrupt therefore reaches whichever bus agent decodes that address, and software can change the route at run time by rewriting one register.

Events are discrete. The unit counts events it has not yet sent, up to a saturation limit, and sends one write for each. An enable bit gates sending but does not gate counting. Events that arrive while sending is disabled are queued and go out once it is enabled again. Each write follows the normal master handshake: the strobe is held while the receiver stalls, and the cycle stays open until an acknowledge or an error ends it. An error response also sets a sticky flag that software can read.

Top module: `msi_gen`

## Requirements
- R1: After reset the target address, data word, enable bit and error flag read as zero, and m_cyc and m_stb are low.
- R2: Slave register map: offset 0 holds the 32-bit target address, offset 1 holds the 32-bit data word, and offset 2 holds the enable bit at bit 0 and the error flag at bit 1 (offset 3 reads zero). Each slave request with s_cyc and s_stb high is answered by s_ack exactly one cycle later, and read data is valid with s_ack.
- R3: While the unit is enabled and at least one event is pending, it opens a master cycle with m_cyc, m_stb and m_we high, m_adr equal to the target address and m_dat_o equal to the data word.
- R4: m_stb stays high while m_stall is high. m_stb falls in the cycle after acceptance (m_stb high and m_stall low). m_cyc stays high until m_ack or m_err, and is low in the cycle after either.
- R5: Each pulse of evt_i (one cycle high) produces its own write, including several pulses raised before any write is sent.
- R6: The pending count saturates at 15. Twenty events raised while the unit is disabled produce exactly fifteen writes after it is enabled.
- R7: While the enable bit is clear no master cycle starts, yet events are still counted.
- R8: m_err ends a cycle just as m_ack does and retires the event. It also sets the error flag at offset 2 bit 1, which stays set until software writes offset 2 with bit 1 set.
- R9: Address and data are captured when a cycle starts and stay stable until it ends. A new target address applies from the next write.
- R10: An event that arrives in the same cycle as a write completes is counted and sent later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| s_cyc | input | 1 | Slave port cycle |
| s_stb | input | 1 | Slave port strobe |
| s_we | input | 1 | Slave port write enable |
| s_adr | input | 2 | Slave register offset |
| s_dat_i | input | 32 | Slave write data |
| s_dat_o | output | 32 | Slave read data |
| s_ack | output | 1 | Slave acknowledge |
| evt_i | input | 1 | Event request pulse from the peripheral |
| m_cyc | output | 1 | Master cycle |
| m_stb | output | 1 | Master strobe |
| m_we | output | 1 | Master write enable |
| m_adr | output | 32 | Master address (target) |
| m_dat_o | output | 32 | Master write data |
| m_ack | input | 1 | Master acknowledge |
| m_err | input | 1 | Master error response |
| m_stall | input | 1 | Master stall |

## Verification
The bench holds the stall line for several cycles and then delays the acknowledge. A design that dropped the strobe early, or closed the cycle before the acknowledge, loses or duplicates the write, and the per-cycle strobe and address checks catch this. The bench queues twenty events while the unit is disabled and then counts the writes. A counter that wrapped instead of saturating would produce four or five writes rather than fifteen, and a unit that sent while disabled would produce a write too early. The bench also raises an event in the same cycle as an acknowledge. A design that let the decrement override the increment would then drop that event. Finally the bench uses an error response and expects the sticky flag to be set and the write to be retired.

// File: rtl/msi_pkg.sv
package msi_pkg;
  localparam int REG_ADR_W = 2;
  localparam logic [REG_ADR_W-1:0] OFS_TARGET = 2'd0;
  localparam logic [REG_ADR_W-1:0] OFS_DATA   = 2'd1;
  localparam logic [REG_ADR_W-1:0] OFS_CTRL   = 2'd2;
  localparam int CTRL_EN_BIT  = 0;
  localparam int CTRL_ERR_BIT = 1;

  typedef enum logic [1:0] {
    MS_IDLE = 2'd0,
    MS_REQ  = 2'd1,
    MS_WAIT = 2'd2
  } mst_state_e;

  // Next pending count: saturating add, plain subtract, net zero when both.
  function automatic int unsigned pend_next(input int unsigned cnt, input logic inc,
                                            input logic dec, input int unsigned lim);
    if (inc && !dec) return (cnt >= lim) ? lim : cnt + 1;
    if (dec && !inc) return (cnt == 0) ? 0 : cnt - 1;
    return cnt;
  endfunction
endpackage

// File: rtl/msi_regs.sv
module msi_regs #(
  parameter int AW = 32,
  parameter int DW = 32
) (
  input  logic                           clk,
  input  logic                           rst,
  input  logic                           s_cyc,
  input  logic                           s_stb,
  input  logic                           s_we,
  input  logic [msi_pkg::REG_ADR_W-1:0]  s_adr,
  input  logic [31:0]                    s_dat_i,
  output logic [31:0]                    s_dat_o,
  output logic                           s_ack,
  input  logic                           err_evt,
  output logic [AW-1:0]                  tgt_adr,
  output logic [DW-1:0]                  tgt_dat,
  output logic                           en,
  output logic                           err_flag
);
  import msi_pkg::*;

  logic req;
  logic wr;
  logic unused_wbits;
  assign req = s_cyc && s_stb && !s_ack;
  assign wr  = req && s_we;
  assign unused_wbits = ^s_dat_i;

  function automatic logic [31:0] rd_mux(input logic [REG_ADR_W-1:0] a,
                                         input logic [AW-1:0] ta, input logic [DW-1:0] td,
                                         input logic e, input logic f);
    logic [31:0] r;
    r = '0;
    case (a)
      OFS_TARGET: r = 32'(ta);
      OFS_DATA:   r = 32'(td);
      OFS_CTRL:   begin r[CTRL_EN_BIT] = e; r[CTRL_ERR_BIT] = f; end
      default:    r = '0;
    endcase
    return r;
  endfunction

  always_ff @(posedge clk) begin
    if (rst) begin
      tgt_adr  <= '0;
      tgt_dat  <= '0;
      en       <= 1'b0;
      err_flag <= 1'b0;
      s_ack    <= 1'b0;
      s_dat_o  <= '0;
    end else begin
      s_ack   <= req;
      s_dat_o <= req ? rd_mux(s_adr, tgt_adr, tgt_dat, en, err_flag) : '0;
      if (wr && s_adr == OFS_TARGET) tgt_adr <= s_dat_i[AW-1:0];
      if (wr && s_adr == OFS_DATA)   tgt_dat <= s_dat_i[DW-1:0];
      if (wr && s_adr == OFS_CTRL)   en      <= s_dat_i[CTRL_EN_BIT];
      if (err_evt)
        err_flag <= 1'b1;
      else if (wr && s_adr == OFS_CTRL && s_dat_i[CTRL_ERR_BIT])
        err_flag <= 1'b0;
    end
  end
endmodule

// File: rtl/msi_pend.sv
module msi_pend #(
  parameter int PEND_MAX = 15,
  localparam int CW = $clog2(PEND_MAX + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          inc,
  input  logic          dec,
  output logic [CW-1:0] cnt,
  output logic          nonzero
);
  import msi_pkg::*;

  always_ff @(posedge clk) begin
    if (rst) cnt <= '0;
    else     cnt <= CW'(pend_next(int'(cnt), inc, dec, PEND_MAX));
  end
  assign nonzero = (cnt != '0);
endmodule

// File: rtl/msi_master.sv
module msi_master #(
  parameter int AW = 32,
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          go,
  input  logic [AW-1:0] tgt_adr,
  input  logic [DW-1:0] tgt_dat,
  output logic          m_cyc,
  output logic          m_stb,
  output logic          m_we,
  output logic [AW-1:0] m_adr,
  output logic [DW-1:0] m_dat_o,
  input  logic          m_ack,
  input  logic          m_err,
  input  logic          m_stall,
  output logic          done,
  output logic          err_evt
);
  import msi_pkg::*;

  mst_state_e st;
  logic       term;

  assign m_cyc   = (st != MS_IDLE);
  assign m_stb   = (st == MS_REQ);
  assign m_we    = m_cyc;
  assign term    = m_cyc && (m_ack || m_err);
  assign done    = term;
  assign err_evt = m_cyc && m_err;

  always_ff @(posedge clk) begin
    if (rst) begin
      st      <= MS_IDLE;
      m_adr   <= '0;
      m_dat_o <= '0;
    end else begin
      case (st)
        MS_IDLE: if (go) begin
          st      <= MS_REQ;
          m_adr   <= tgt_adr;
          m_dat_o <= tgt_dat;
        end
        MS_REQ:  if (term) st <= MS_IDLE;
                 else if (!m_stall) st <= MS_WAIT;
        MS_WAIT: if (term) st <= MS_IDLE;
        default: st <= MS_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/msi_gen.sv
module msi_gen #(
  parameter int AW = 32,
  parameter int DW = 32,
  parameter int PEND_MAX = 15,
  localparam int CW = $clog2(PEND_MAX + 1)
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        s_cyc,
  input  logic        s_stb,
  input  logic        s_we,
  input  logic [1:0]  s_adr,
  input  logic [31:0] s_dat_i,
  output logic [31:0] s_dat_o,
  output logic        s_ack,
  input  logic        evt_i,
  output logic        m_cyc,
  output logic        m_stb,
  output logic        m_we,
  output logic [AW-1:0] m_adr,
  output logic [DW-1:0] m_dat_o,
  input  logic        m_ack,
  input  logic        m_err,
  input  logic        m_stall
);
  logic [AW-1:0] tgt_adr;
  logic [DW-1:0] tgt_dat;
  logic          en;
  logic          err_flag;
  logic          err_evt;
  logic          done;
  logic [CW-1:0] pend_cnt;
  logic          pend_nz;
  logic          go;

  assign go = en && pend_nz && !m_cyc;

  msi_regs #(.AW(AW), .DW(DW)) u_regs (
    .clk(clk), .rst(rst), .s_cyc(s_cyc), .s_stb(s_stb), .s_we(s_we), .s_adr(s_adr),
    .s_dat_i(s_dat_i), .s_dat_o(s_dat_o), .s_ack(s_ack), .err_evt(err_evt),
    .tgt_adr(tgt_adr), .tgt_dat(tgt_dat), .en(en), .err_flag(err_flag)
  );

  msi_pend #(.PEND_MAX(PEND_MAX)) u_pend (
    .clk(clk), .rst(rst), .inc(evt_i), .dec(done), .cnt(pend_cnt), .nonzero(pend_nz)
  );

  msi_master #(.AW(AW), .DW(DW)) u_mst (
    .clk(clk), .rst(rst), .go(go), .tgt_adr(tgt_adr), .tgt_dat(tgt_dat),
    .m_cyc(m_cyc), .m_stb(m_stb), .m_we(m_we), .m_adr(m_adr), .m_dat_o(m_dat_o),
    .m_ack(m_ack), .m_err(m_err), .m_stall(m_stall), .done(done), .err_evt(err_evt)
  );
endmodule

// File: rtl/msi_gen_sva.sv
module msi_gen_sva #(
  parameter int AW = 32,
  parameter int DW = 32,
  parameter int PEND_MAX = 15,
  localparam int CW = $clog2(PEND_MAX + 1)
) (
  input logic          clk,
  input logic          rst,
  input logic          s_cyc,
  input logic          s_stb,
  input logic          s_ack,
  input logic          evt_i,
  input logic          m_cyc,
  input logic          m_stb,
  input logic          m_we,
  input logic [AW-1:0] m_adr,
  input logic [DW-1:0] m_dat_o,
  input logic          m_ack,
  input logic          m_err,
  input logic          m_stall,
  input logic          en,
  input logic          err_flag,
  input logic [CW-1:0] pend_cnt
);
  a_r2_ack_follows_req: assert property (@(posedge clk) disable iff (rst)
    s_ack |-> $past(s_cyc && s_stb));
  a_r3_write_only: assert property (@(posedge clk) disable iff (rst)
    m_cyc |-> m_we);
  a_r4_stb_in_cyc: assert property (@(posedge clk) disable iff (rst)
    m_stb |-> m_cyc);
  a_r4_hold_on_stall: assert property (@(posedge clk) disable iff (rst)
    m_stb && m_stall && !m_ack && !m_err |=> m_stb);
  a_r4_drop_after_accept: assert property (@(posedge clk) disable iff (rst)
    m_stb && !m_stall |=> !m_stb);
  a_r4_cyc_until_ack: assert property (@(posedge clk) disable iff (rst)
    m_cyc && !m_ack && !m_err |=> m_cyc);
  a_r4_close_on_ack: assert property (@(posedge clk) disable iff (rst)
    m_cyc && (m_ack || m_err) |=> !m_cyc);
  a_r6_saturate: assert property (@(posedge clk) disable iff (rst)
    (int'(pend_cnt) == PEND_MAX) && evt_i && !(m_cyc && (m_ack || m_err))
    |=> int'(pend_cnt) == PEND_MAX);
  a_r7_no_start_disabled: assert property (@(posedge clk) disable iff (rst)
    !en && !m_cyc |=> !m_cyc);
  a_r8_err_sticky: assert property (@(posedge clk) disable iff (rst)
    m_cyc && m_err |=> err_flag);
  a_r9_stable_payload: assert property (@(posedge clk) disable iff (rst)
    m_cyc && !m_ack && !m_err |=> $stable(m_adr) && $stable(m_dat_o));
  a_r10_event_counted: assert property (@(posedge clk) disable iff (rst)
    evt_i && (int'(pend_cnt) < PEND_MAX) && !(m_cyc && (m_ack || m_err))
    |=> pend_cnt == $past(pend_cnt) + 1'b1);
endmodule

bind msi_gen msi_gen_sva #(.AW(AW), .DW(DW), .PEND_MAX(PEND_MAX)) u_sva (
  .clk(clk), .rst(rst), .s_cyc(s_cyc), .s_stb(s_stb), .s_ack(s_ack), .evt_i(evt_i),
  .m_cyc(m_cyc), .m_stb(m_stb), .m_we(m_we), .m_adr(m_adr), .m_dat_o(m_dat_o),
  .m_ack(m_ack), .m_err(m_err), .m_stall(m_stall), .en(en), .err_flag(err_flag),
  .pend_cnt(pend_cnt)
);

// File: tb/msi_gen_tb.sv
module msi_gen_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        s_cyc = 0, s_stb = 0, s_we = 0;
  logic [1:0]  s_adr = 0;
  logic [31:0] s_dat_i = 0;
  logic [31:0] s_dat_o;
  logic        s_ack;
  logic        evt_i = 0;
  logic        m_cyc, m_stb, m_we;
  logic [31:0] m_adr, m_dat_o;
  logic        m_ack = 0, m_err = 0, m_stall = 1;

  int n_chk = 0;
  int n_bad = 0;
  bit done_flag = 0;

  always #5 clk = ~clk;

  msi_gen u_dut (
    .clk(clk), .rst(rst), .s_cyc(s_cyc), .s_stb(s_stb), .s_we(s_we), .s_adr(s_adr),
    .s_dat_i(s_dat_i), .s_dat_o(s_dat_o), .s_ack(s_ack), .evt_i(evt_i),
    .m_cyc(m_cyc), .m_stb(m_stb), .m_we(m_we), .m_adr(m_adr), .m_dat_o(m_dat_o),
    .m_ack(m_ack), .m_err(m_err), .m_stall(m_stall)
  );

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic tick;
    @(posedge clk); @(negedge clk);
  endtask

  task automatic reg_wr(input logic [1:0] a, input logic [31:0] d);
    s_cyc = 1; s_stb = 1; s_we = 1; s_adr = a; s_dat_i = d;
    tick;
    check(s_ack === 1'b1, "R2 write ack", {31'd0, s_ack}, 1);
    s_cyc = 0; s_stb = 0; s_we = 0;
    tick;
  endtask

  task automatic reg_rd(input logic [1:0] a, output logic [31:0] d);
    s_cyc = 1; s_stb = 1; s_we = 0; s_adr = a;
    tick;
    check(s_ack === 1'b1, "R2 read ack", {31'd0, s_ack}, 1);
    d = s_dat_o;
    s_cyc = 0; s_stb = 0;
    tick;
  endtask

  task automatic pulse_evt(input int n);
    for (int i = 0; i < n; i++) begin
      evt_i = 1; tick; evt_i = 0; tick;
    end
  endtask

  // Serve one master write; seen=0 if no strobe within the window.
  task automatic serve(input int stall_n, input int ack_dly, input bit use_err, input bit evt_at_end,
                       input logic [31:0] ea, input logic [31:0] ed, output bit seen);
    int w = 0;
    seen = 0;
    while (!m_stb && w < 40) begin tick; w++; end
    if (!m_stb) return;
    seen = 1;
    check(m_cyc && m_we, "R3 cyc and we", {30'd0, m_cyc, m_we}, 3);
    check(m_adr === ea, "R3 address", m_adr, ea);
    check(m_dat_o === ed, "R3 data", m_dat_o, ed);
    for (int i = 0; i < stall_n; i++) begin
      tick;
      check(m_stb === 1'b1, "R4 stb held in stall", {31'd0, m_stb}, 1);
      check(m_adr === ea, "R9 address stable", m_adr, ea);
    end
    m_stall = 0; tick; m_stall = 1;
    check(!m_stb && m_cyc, "R4 stb drops, cyc stays", {30'd0, m_cyc, m_stb}, 2);
    for (int i = 0; i < ack_dly; i++) begin
      tick;
      check(m_cyc === 1'b1, "R4 cyc open until ack", {31'd0, m_cyc}, 1);
      check(m_dat_o === ed, "R9 data stable", m_dat_o, ed);
    end
    if (use_err) m_err = 1; else m_ack = 1;
    if (evt_at_end) evt_i = 1;
    tick;
    m_ack = 0; m_err = 0; evt_i = 0;
    check(m_cyc === 1'b0, "R4 cyc closes after ack", {31'd0, m_cyc}, 0);
  endtask

  task automatic drain(input logic [31:0] ea, input logic [31:0] ed, output int n);
    bit seen;
    n = 0;
    do begin
      serve(0, 0, 0, 0, ea, ed, seen);
      if (seen) n++;
    end while (seen && n < 40);
  endtask

  task automatic t_reset;
    logic [31:0] d;
    check(!m_cyc && !m_stb, "R1 master idle", {30'd0, m_cyc, m_stb}, 0);
    reg_rd(2'd0, d); check(d == 0, "R1 target zero", d, 0);
    reg_rd(2'd1, d); check(d == 0, "R1 data zero", d, 0);
    reg_rd(2'd2, d); check(d == 0, "R1 ctrl zero", d, 0);
  endtask

  task automatic t_regs;
    logic [31:0] d;
    reg_wr(2'd0, 32'h8000_1230);
    reg_wr(2'd1, 32'h0000_00A5);
    reg_rd(2'd0, d); check(d == 32'h8000_1230, "R2 target readback", d, 32'h8000_1230);
    reg_rd(2'd1, d); check(d == 32'h0000_00A5, "R2 data readback", d, 32'h0000_00A5);
    reg_rd(2'd3, d); check(d == 0, "R2 offset 3 zero", d, 0);
  endtask

  task automatic t_disabled_queue;
    int n;
    pulse_evt(3);
    repeat (20) begin
      tick;
      if (m_cyc) check(0, "R7 no cycle while disabled", 1, 0);
    end
    check(!m_cyc, "R7 idle while disabled", {31'd0, m_cyc}, 0);
    reg_wr(2'd2, 32'd1);
    drain(32'h8000_1230, 32'h0000_00A5, n);
    check(n == 3, "R5 three queued writes", n, 3);
  endtask

  task automatic t_stall;
    bit seen;
    pulse_evt(1);
    serve(3, 2, 0, 0, 32'h8000_1230, 32'h0000_00A5, seen);
    check(seen, "R4 stalled write seen", {31'd0, seen}, 1);
  endtask

  task automatic t_saturate;
    int n;
    reg_wr(2'd2, 32'd0);
    pulse_evt(20);
    reg_wr(2'd2, 32'd1);
    drain(32'h8000_1230, 32'h0000_00A5, n);
    check(n == 15, "R6 saturated write count", n, 15);
  endtask

  task automatic t_error;
    bit seen;
    int n;
    logic [31:0] d;
    pulse_evt(1);
    serve(0, 1, 1, 0, 32'h8000_1230, 32'h0000_00A5, seen);
    check(seen, "R8 error write seen", {31'd0, seen}, 1);
    drain(32'h8000_1230, 32'h0000_00A5, n);
    check(n == 0, "R8 error retires event", n, 0);
    reg_rd(2'd2, d); check(d == 32'd3, "R8 error flag set", d, 3);
    reg_wr(2'd2, 32'd1);
    reg_rd(2'd2, d); check(d == 32'd3, "R8 flag sticky", d, 3);
    reg_wr(2'd2, 32'd3);
    reg_rd(2'd2, d); check(d == 32'd1, "R8 flag cleared", d, 1);
  endtask

  task automatic t_overlap;
    bit seen;
    int n;
    pulse_evt(1);
    serve(0, 1, 0, 1, 32'h8000_1230, 32'h0000_00A5, seen);
    drain(32'h8000_1230, 32'h0000_00A5, n);
    check(n == 1, "R10 event at completion sent", n, 1);
  endtask

  task automatic t_retarget;
    int n;
    reg_wr(2'd0, 32'h4000_0010);
    reg_wr(2'd1, 32'h1234_5678);
    pulse_evt(2);
    drain(32'h4000_0010, 32'h1234_5678, n);
    check(n == 2, "R9 new target used", n, 2);
  endtask

  initial begin
    repeat (3) tick;
    rst = 0;
    tick;
    t_reset;
    t_regs;
    t_disabled_queue;
    t_stall;
    t_saturate;
    t_error;
    t_overlap;
    t_retarget;
    done_flag = 1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done_flag) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=%h expected=%h", 0, 1);
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end
endmodule